// File: doc/BRIEF.md
# Packed-Lane Carry-Less / Integer Vector Multiplier

This block performs one lane-wise multiply on two 128-bit source vectors and returns a 128-bit destination vector. A 32-bit instruction word travels with the operands. The block decodes the lane width, the vector length and the arithmetic mode from that word. In integer mode each lane gets an ordinary unsigned product. In polynomial mode each lane gets a carry-less product over GF(2). In both modes only the low lane-width bits of each product are kept.

Some encodings are reserved, and a word that is not this operation at all is also rejected. In either case the block raises an undefined flag instead of producing a result. The latency is fixed at two cycles whatever the operand values, and a new operation may be issued on every cycle. The surrounding pipeline presents operands with a valid strobe and collects the result when the matching output strobe appears.

Top module: `lane_mul_unit`

## Requirements
- R1: The word is recognised only when bit 31 is 0, bits 28:24 are 01110, bit 21 is 1 and bits 15:10 are 100111. Any other value in those bits gives an undefined result. The register-number fields in bits 20:16, 9:5 and 4:0 do not affect the outcome.
- R2: The two-bit size field in bits 23:22 selects lanes of 8 (00), 16 (01) or 32 (10) bits. Lane e occupies bits e*w upward of each operand and of the result, and each lane is computed independently of its neighbours.
- R3: When the mode bit (bit 29) is 0, each lane of the result is the low lane-width bits of the unsigned product of the two source lanes.
- R4: When the mode bit is 1 and size is 00, each 8-bit lane of the result is the low 8 bits of the carry-less product, formed by XOR-accumulating the shifted partial products.
- R5: The length bit (bit 30) selects a 128-bit vector when 1 and a 64-bit vector when 0. With a 64-bit vector, result bits 127:64 are zero.
- R6: Size 11 is undefined, and mode bit 1 with any size other than 00 is undefined. For an undefined operation undef_out is 1 with valid_out and the result is all zeros.
- R7: A valid_in pulse produces valid_out exactly two cycles later, with no dependence on operand values. Operations issued on consecutive cycles come out on consecutive cycles, in order.
- R8: While reset is asserted, valid_out and undef_out are 0 and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operation present on the inputs this cycle |
| insn | input | 32 | Instruction word carrying size, length and mode |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| valid_out | output | 1 | Result present, two cycles after valid_in |
| undef_out | output | 1 | Operation was reserved or not recognised |
| result | output | 128 | Destination vector, lane products truncated |

## Verification
A wrong lane-select or mode decode shows up at the ports as a corrupted result on the very cycle valid_out rises. That cycle is two edges after issue, so every directed operation exposes such a fault at once. A fault in the carry or XOR paths only appears for operands whose partial products overlap. All-ones operands reach every overlap, and single-bit operands show misplaced shifts and lane boundaries. A broken valid pipeline shows as a strobe one cycle early or late, which the one-cycle-after-issue check and the back-to-back sequence catch within three cycles.

// File: rtl/lane_mul_pkg.sv
package lane_mul_pkg;

  localparam int INSN_W = 32;

  typedef struct packed {
    logic       match;   // fixed opcode bits agree
    logic       undef;   // reserved or unrecognised
    logic       poly;    // carry-less mode
    logic       full;    // 128-bit vector
    logic [1:0] size;    // lane width code
  } mul_op_t;

  // Opcode match: all fixed positions compared at once.
  function automatic logic opcode_hit(input logic [INSN_W-1:0] w);
    return (w[31] == 1'b0) && (w[28:24] == 5'b01110) &&
           (w[21] == 1'b1) && (w[15:10] == 6'b100111);
  endfunction

  function automatic mul_op_t decode_word(input logic [INSN_W-1:0] w);
    mul_op_t o;
    o.match = opcode_hit(w);
    o.poly  = w[29];
    o.full  = w[30];
    o.size  = w[23:22];
    o.undef = !o.match || (o.size == 2'b11) || (o.poly && o.size != 2'b00);
    return o;
  endfunction

endpackage

// File: rtl/lane_mul_decode.sv
module lane_mul_decode
  import lane_mul_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output mul_op_t           op,
  output logic              opcode_ok
);
  always_comb begin
    op        = decode_word(insn);
    opcode_ok = op.match;
  end
endmodule

// File: rtl/lane_mul_lanes.sv
module lane_mul_lanes #(
  parameter int VEC_W   = 128,
  parameter int EW      = 8,
  parameter bit POLY_EN = 1'b1
) (
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic             poly,
  output logic [VEC_W-1:0] prod
);
  localparam int NLANE = VEC_W / EW;

  // Carry-less product, low EW bits only.
  function automatic logic [EW-1:0] clmul_lo(input logic [EW-1:0] x,
                                             input logic [EW-1:0] y);
    logic [EW-1:0] acc;
    acc = '0;
    for (int i = 0; i < EW; i++)
      if (y[i]) acc = acc ^ (x << i);
    return acc;
  endfunction

  // Unsigned product, low EW bits only.
  function automatic logic [EW-1:0] umul_lo(input logic [EW-1:0] x,
                                            input logic [EW-1:0] y);
    return x * y;
  endfunction

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [EW-1:0] ea, eb, ip;
    assign ea = op_a[g*EW +: EW];
    assign eb = op_b[g*EW +: EW];
    assign ip = umul_lo(ea, eb);
    if (POLY_EN) begin : g_poly
      logic [EW-1:0] cp;
      assign cp = clmul_lo(ea, eb);
      assign prod[g*EW +: EW] = poly ? cp : ip;
    end else begin : g_int
      // Poly at this width is reserved; the top zeroes it anyway.
      assign prod[g*EW +: EW] = poly ? '0 : ip;
    end
  end
endmodule

// File: rtl/lane_mul_unit.sv
module lane_mul_unit
  import lane_mul_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [31:0]       insn,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  output logic              valid_out,
  output logic              undef_out,
  output logic [VEC_W-1:0]  result
);
  localparam int HALF_W = VEC_W / 2;
  localparam int NSIZE  = 3;

  // Stage 1: operand capture
  logic              s1_valid;
  logic [31:0]       s1_insn;
  logic [VEC_W-1:0]  s1_a, s1_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_insn  <= '0;
      s1_a     <= '0;
      s1_b     <= '0;
    end else begin
      s1_valid <= valid_in;
      if (valid_in) begin
        s1_insn <= insn;
        s1_a    <= src_a;
        s1_b    <= src_b;
      end
    end
  end

  // Decode and lane arithmetic
  mul_op_t dec;
  logic    dec_opcode_ok;

  lane_mul_decode u_dec (
    .insn      (s1_insn),
    .op        (dec),
    .opcode_ok (dec_opcode_ok)
  );

  logic [VEC_W-1:0] lane_prod [NSIZE];

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    lane_mul_lanes #(
      .VEC_W   (VEC_W),
      .EW      (8 << s),
      .POLY_EN (s == 0)
    ) u_lanes (
      .op_a (s1_a),
      .op_b (s1_b),
      .poly (dec.poly),
      .prod (lane_prod[s])
    );
  end

  logic [VEC_W-1:0] sel_vec;
  logic             drop_high;

  always_comb begin
    case (dec.size)
      2'd0:    sel_vec = lane_prod[0];
      2'd1:    sel_vec = lane_prod[1];
      2'd2:    sel_vec = lane_prod[2];
      default: sel_vec = '0;
    endcase
    drop_high = !dec.full;
    if (drop_high) sel_vec[VEC_W-1:HALF_W] = '0;
    if (dec.undef) sel_vec = '0;
  end

  // Stage 2: output registers
  logic out_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      undef_out <= 1'b0;
      result    <= '0;
      out_half  <= 1'b0;
    end else begin
      valid_out <= s1_valid;
      if (s1_valid) begin
        undef_out <= dec.undef;
        result    <= sel_vec;
        out_half  <= drop_high;
      end
    end
  end

  // Assertions
  a_r7_fill: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> valid_out);

  a_r7_source: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> $past(s1_valid));

  a_r6_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && undef_out) |-> (result == '0));

  a_r5_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && out_half) |-> (result[VEC_W-1:HALF_W] == '0));

  a_r1_nomatch_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !dec_opcode_ok) |=> undef_out);

endmodule

// File: tb/lane_mul_unit_tb.sv
module lane_mul_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_in = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] src_a = '0, src_b = '0;
  logic         valid_out, undef_out;
  logic [127:0] result;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_mul_unit u_dut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .insn(insn),
    .src_a(src_a), .src_b(src_b),
    .valid_out(valid_out), .undef_out(undef_out), .result(result)
  );

  function automatic logic [31:0] mk(input logic q, input logic u,
                                     input logic [1:0] sz);
    return {1'b0, q, u, 5'b01110, sz, 1'b1, 5'($urandom), 6'b100111,
            5'($urandom), 5'($urandom)};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Bit-serial reference: {undef, result}
  function automatic logic [128:0] ref_vec(input logic [31:0] w,
                                           input logic [127:0] a,
                                           input logic [127:0] b);
    logic [1:0]   sz = w[23:22];
    logic         u  = w[29];
    logic         ok;
    int           ew, nl;
    logic [127:0] r = '0;
    ok = !w[31] && w[28:24] == 5'b01110 && w[21] && w[15:10] == 6'b100111;
    if (!ok || sz == 2'b11 || (u && sz != 2'b00)) return {1'b1, 128'd0};
    ew = 8 << sz;
    nl = (w[30] ? 128 : 64) / ew;
    for (int e = 0; e < nl; e++) begin
      logic [63:0] x, y, acc, msk;
      msk = (64'd1 << ew) - 64'd1;
      x = 64'(a >> (e * ew)) & msk;
      y = 64'(b >> (e * ew)) & msk;
      acc = '0;
      for (int i = 0; i < ew; i++)
        if (y[i]) acc = u ? (acc ^ (x << i)) : (acc + (x << i));
      r = r | (128'(acc & msk) << (e * ew));
    end
    return {1'b0, r};
  endfunction

  task automatic check_out(input string req, input logic [127:0] w,
                           input logic [127:0] a, input logic [127:0] b);
    logic [128:0] ex = ref_vec(w[31:0], a, b);
    n_cmp++;
    if (valid_out !== 1'b1 || undef_out !== ex[128] || result !== ex[127:0]) begin
      n_bad++;
      $display("FAIL %s: valid=%b undef=%b result=%h expected valid=1 undef=%b result=%h",
               req, valid_out, undef_out, result, ex[128], ex[127:0]);
    end
  endtask

  // Single issue: valid_out must be low one cycle later, high two later.
  task automatic issue(input string req, input logic [31:0] w,
                       input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    valid_in = 1'b1; insn = w; src_a = a; src_b = b;
    @(negedge clk);
    valid_in = 1'b0; src_a = rnd128(); src_b = rnd128();
    n_cmp++;
    if (valid_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R7 early strobe (%s): valid_out=%b expected 0", req, valid_out);
    end
    @(negedge clk);
    check_out(req, {96'd0, w}, a, b);
  endtask

  task automatic t_reset();  // R8
    n_cmp++;
    if (valid_out !== 1'b0 || undef_out !== 1'b0 || result !== '0) begin
      n_bad++;
      $display("FAIL R8 reset: valid=%b undef=%b result=%h expected 0 0 0",
               valid_out, undef_out, result);
    end
  endtask

  task automatic t_integer();  // R2 R3 R5
    for (int sz = 0; sz < 3; sz++)
      for (int q = 0; q < 2; q++)
        for (int k = 0; k < 3; k++)
          issue("R2/R3/R5 integer lanes", mk(q[0], 1'b0, sz[1:0]), rnd128(), rnd128());
  endtask

  task automatic t_poly();  // R4 R5
    for (int q = 0; q < 2; q++)
      for (int k = 0; k < 4; k++)
        issue("R4/R5 carry-less lanes", mk(q[0], 1'b1, 2'b00), rnd128(), rnd128());
  endtask

  task automatic t_edges();  // R3 R4 R2
    for (int sz = 0; sz < 3; sz++)
      issue("R3 all-ones integer", mk(1'b1, 1'b0, sz[1:0]), '1, '1);
    issue("R4 all-ones carry-less", mk(1'b1, 1'b1, 2'b00), '1, '1);
    for (int bp = 0; bp < 8; bp++) begin
      issue("R4 single-bit carry-less", mk(1'b1, 1'b1, 2'b00),
            {16{8'(1 << bp)}}, '1);
      issue("R2 single-bit integer", mk(1'b1, 1'b0, 2'(bp % 3)),
            128'd1 << (bp * 16), rnd128());
    end
  endtask

  task automatic t_reserved();  // R6
    for (int q = 0; q < 2; q++) begin
      issue("R6 size 11 integer", mk(q[0], 1'b0, 2'b11), rnd128(), rnd128());
      issue("R6 size 11 poly", mk(q[0], 1'b1, 2'b11), rnd128(), rnd128());
      issue("R6 poly size 01", mk(q[0], 1'b1, 2'b01), rnd128(), rnd128());
      issue("R6 poly size 10", mk(q[0], 1'b1, 2'b10), rnd128(), rnd128());
    end
  endtask

  task automatic t_fixed_bits();  // R1
    int fixed_pos[13] = '{31, 28, 27, 26, 25, 24, 21, 15, 14, 13, 12, 11, 10};
    foreach (fixed_pos[i]) begin
      logic [31:0] w = mk(1'b1, 1'b0, 2'b00);
      w[fixed_pos[i]] = ~w[fixed_pos[i]];
      issue("R1 fixed bit flipped", w, rnd128(), rnd128());
    end
  endtask

  task automatic t_back_to_back();  // R7
    logic [31:0]  ws[3];
    logic [127:0] as[3], bs[3];
    ws[0] = mk(1'b1, 1'b1, 2'b00);
    ws[1] = mk(1'b0, 1'b0, 2'b10);
    ws[2] = mk(1'b1, 1'b0, 2'b11);
    for (int i = 0; i < 3; i++) begin
      as[i] = rnd128();
      bs[i] = rnd128();
    end
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k >= 2) check_out("R7 back-to-back", {96'd0, ws[k-2]}, as[k-2], bs[k-2]);
      if (k < 3) begin
        valid_in = 1'b1; insn = ws[k]; src_a = as[k]; src_b = bs[k];
      end else valid_in = 1'b0;
    end
    @(negedge clk);
    n_cmp++;
    if (valid_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R7 trailing strobe: valid_out=%b expected 0", valid_out);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_integer();
    t_poly();
    t_edges();
    t_reserved();
    t_fixed_bits();
    t_back_to_back();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule